// File: doc/BRIEF.md
# Dual-Output Source Router

This block is the meeting point of a small processor's sub-units. The timer, I/O, FIFO, LIFO, ALU and program-counter logic do not connect to each other. Each presents its value to this router, and the current instruction decides where that value goes. There are two registered destinations: a register-A port and a multiplier/data-out port. Both destinations read from one shared source map in which each source has the same position for both. Each destination has its own 4-bit source select.

A bus transfer is requested with a transfer strobe and a one-bit destination choice. On the clock edge, only the chosen destination loads the source named by its own select, and the other destination holds its value. The router also keeps a constant register. When the decoder marks an instruction word as data rather than an executable instruction, the whole word is captured there, and the register is then readable as source code 0000.

Top module: `dbus_router`

## Requirements
- R1: A synchronous active-high reset clears both outputs and the constant register to zero. The cleared constant register is observed by a later transfer with code 0000.
- R2: The select codes map to sources as follows: 0001 timer write register, 0010 I/O write register, 0011 LIFO input register, 0100 FIFO input register, 0101 I/O read register, 0110 program counter, 0111 I/O unit output, 1000 ALU result, 1001 FIFO output, 1010 LIFO output.
- R3: Code 0000 selects the constant register. On a rising edge where the data-word strobe is high, that register loads the full 16-bit instruction word.
- R4: Codes 1011 to 1111 route zero. A transfer with such a code still updates the targeted output, to zero.
- R5: On a transfer edge, only the destination named by the destination bit loads (0 = register A, 1 = multiplier out). The other destination keeps its value.
- R6: With the transfer strobe low, both outputs hold their values whatever the selects and sources do.
- R7: Both destinations use the same source map, so equal select values deliver equal values.
- R8: If a data-word load and a transfer with code 0000 fall on the same edge, the transfer delivers the value the constant register held before that edge.
- R9: With the data-word strobe low, the constant register keeps its value while the instruction word changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_word | input | 16 | Current instruction word |
| instr_is_data | input | 1 | Decoder flag: the word is data, so load the constant register |
| timer_wr_reg | input | 16 | Timer write register (code 0001) |
| io_wr_reg | input | 16 | I/O write register (code 0010) |
| lifo_wr_reg | input | 16 | LIFO input register (code 0011) |
| fifo_wr_reg | input | 16 | FIFO input register (code 0100) |
| io_rd_reg | input | 16 | I/O read register (code 0101) |
| pc_val | input | 16 | Program counter (code 0110) |
| io_unit_out | input | 16 | I/O unit output (code 0111) |
| alu_result | input | 16 | ALU result (code 1000) |
| fifo_pop_val | input | 16 | FIFO output (code 1001) |
| lifo_pop_val | input | 16 | LIFO output (code 1010) |
| xfer_en | input | 1 | Bus-transfer strobe |
| xfer_dest | input | 1 | Target: 0 register A, 1 multiplier out |
| rega_sel | input | 4 | Source select for register A |
| multo_sel | input | 4 | Source select for multiplier out |
| rega_out | output | 16 | Register-A destination |
| multo_out | output | 16 | Multiplier/data-out destination |

## Verification
The bench builds the router with its default 16-bit data path and 4-bit selects. At this width every one of the sixteen codes, including all five unconnected ones, can be driven exhaustively on both destinations. Distinct per-source bit patterns make a wrong source position show up as a wrong value. Directed sequences then place a data-word load on the same edge as a code-0000 transfer, and a randomized phase mixes loads, idle cycles and transfers to both destinations.

// File: rtl/dbus_pkg.sv
package dbus_pkg;
  localparam int SEL_W   = 4;
  localparam int NUM_SRC = 11;

  typedef enum logic [SEL_W-1:0] {
    SRC_CONST    = 4'd0,
    SRC_TIMER_WR = 4'd1,
    SRC_IO_WR    = 4'd2,
    SRC_LIFO_WR  = 4'd3,
    SRC_FIFO_WR  = 4'd4,
    SRC_IO_RD    = 4'd5,
    SRC_PC       = 4'd6,
    SRC_IO_OUT   = 4'd7,
    SRC_ALU      = 4'd8,
    SRC_FIFO_OUT = 4'd9,
    SRC_LIFO_OUT = 4'd10
  } src_code_e;

  typedef enum logic {
    DEST_REGA  = 1'b0,
    DEST_MULTO = 1'b1
  } dest_e;

  // a select code reaches a wired source only below the source count
  function automatic logic code_is_wired(input logic [SEL_W-1:0] code);
    return 32'(code) < NUM_SRC;
  endfunction
endpackage

// File: rtl/dbus_const_reg.sv
module dbus_const_reg #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld,
  input  logic [DATA_W-1:0] d,
  output logic [DATA_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (ld) q <= d;
  end
endmodule

// File: rtl/dbus_src_mux.sv
module dbus_src_mux #(
  parameter int DATA_W  = 16,
  parameter int NUM_SRC = 11,
  parameter int SEL_W   = 4
) (
  input  logic [NUM_SRC-1:0][DATA_W-1:0] srcs,
  input  logic [SEL_W-1:0]               sel,
  output logic [DATA_W-1:0]              sel_val
);
  always_comb begin
    sel_val = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (sel == SEL_W'(i)) sel_val = srcs[i];
    end
  end
endmodule

// File: rtl/dbus_out_reg.sv
module dbus_out_reg #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld,
  input  logic [DATA_W-1:0] d,
  output logic [DATA_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (ld) q <= d;
  end
endmodule

// File: rtl/dbus_router.sv
module dbus_router
  import dbus_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] instr_word,
  input  logic              instr_is_data,
  input  logic [DATA_W-1:0] timer_wr_reg,
  input  logic [DATA_W-1:0] io_wr_reg,
  input  logic [DATA_W-1:0] lifo_wr_reg,
  input  logic [DATA_W-1:0] fifo_wr_reg,
  input  logic [DATA_W-1:0] io_rd_reg,
  input  logic [DATA_W-1:0] pc_val,
  input  logic [DATA_W-1:0] io_unit_out,
  input  logic [DATA_W-1:0] alu_result,
  input  logic [DATA_W-1:0] fifo_pop_val,
  input  logic [DATA_W-1:0] lifo_pop_val,
  input  logic              xfer_en,
  input  logic              xfer_dest,
  input  logic [SEL_W-1:0]  rega_sel,
  input  logic [SEL_W-1:0]  multo_sel,
  output logic [DATA_W-1:0] rega_out,
  output logic [DATA_W-1:0] multo_out
);
  localparam int NUM_DEST = 2;

  logic [DATA_W-1:0]               const_q;
  logic [NUM_SRC-1:0][DATA_W-1:0]  src_bus;
  logic [NUM_DEST-1:0][SEL_W-1:0]  dest_sel;
  logic [NUM_DEST-1:0][DATA_W-1:0] dest_next;
  logic [NUM_DEST-1:0][DATA_W-1:0] dest_q;
  logic [NUM_DEST-1:0]             dest_ld;

  // named events for the checker
  logic              rega_load, multo_load;
  logic [DATA_W-1:0] rega_next, multo_next;

  dbus_const_reg #(.DATA_W(DATA_W)) u_const (
    .clk(clk), .rst(rst), .ld(instr_is_data), .d(instr_word), .q(const_q)
  );

  always_comb begin
    src_bus               = '0;
    src_bus[SRC_CONST]    = const_q;
    src_bus[SRC_TIMER_WR] = timer_wr_reg;
    src_bus[SRC_IO_WR]    = io_wr_reg;
    src_bus[SRC_LIFO_WR]  = lifo_wr_reg;
    src_bus[SRC_FIFO_WR]  = fifo_wr_reg;
    src_bus[SRC_IO_RD]    = io_rd_reg;
    src_bus[SRC_PC]       = pc_val;
    src_bus[SRC_IO_OUT]   = io_unit_out;
    src_bus[SRC_ALU]      = alu_result;
    src_bus[SRC_FIFO_OUT] = fifo_pop_val;
    src_bus[SRC_LIFO_OUT] = lifo_pop_val;
  end

  assign dest_sel[DEST_REGA]  = rega_sel;
  assign dest_sel[DEST_MULTO] = multo_sel;

  for (genvar g = 0; g < NUM_DEST; g++) begin : g_dest
    dbus_src_mux #(.DATA_W(DATA_W), .NUM_SRC(NUM_SRC), .SEL_W(SEL_W)) u_mux (
      .srcs(src_bus), .sel(dest_sel[g]), .sel_val(dest_next[g])
    );
    assign dest_ld[g] = xfer_en && (xfer_dest == 1'(g));
    dbus_out_reg #(.DATA_W(DATA_W)) u_out (
      .clk(clk), .rst(rst), .ld(dest_ld[g]), .d(dest_next[g]), .q(dest_q[g])
    );
  end

  assign rega_load  = dest_ld[DEST_REGA];
  assign multo_load = dest_ld[DEST_MULTO];
  assign rega_next  = dest_next[DEST_REGA];
  assign multo_next = dest_next[DEST_MULTO];
  assign rega_out   = dest_q[DEST_REGA];
  assign multo_out  = dest_q[DEST_MULTO];
endmodule

// File: rtl/dbus_router_chk.sv
module dbus_router_chk
  import dbus_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic [DATA_W-1:0] instr_word,
  input logic              instr_is_data,
  input logic              xfer_en,
  input logic              xfer_dest,
  input logic [SEL_W-1:0]  rega_sel,
  input logic [SEL_W-1:0]  multo_sel,
  input logic [DATA_W-1:0] const_q,
  input logic              rega_load,
  input logic              multo_load,
  input logic [DATA_W-1:0] rega_out,
  input logic [DATA_W-1:0] multo_out
);
  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (rega_out == '0 && multo_out == '0 && const_q == '0));

  assert_const_load_R3: assert property (@(posedge clk) disable iff (rst)
    instr_is_data |=> const_q == $past(instr_word));

  assert_unwired_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (xfer_en && !xfer_dest && !code_is_wired(rega_sel)) |=> rega_out == '0);

  assert_unwired_zero_m_R4: assert property (@(posedge clk) disable iff (rst)
    (xfer_en && xfer_dest && !code_is_wired(multo_sel)) |=> multo_out == '0);

  assert_one_target_R5: assert property (@(posedge clk) disable iff (rst)
    !(rega_load && multo_load));

  assert_multo_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (xfer_en && !xfer_dest) |=> $stable(multo_out));

  assert_rega_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (xfer_en && xfer_dest) |=> $stable(rega_out));

  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !xfer_en |=> ($stable(rega_out) && $stable(multo_out)));

  assert_old_const_R8: assert property (@(posedge clk) disable iff (rst)
    (xfer_en && !xfer_dest && rega_sel == SRC_CONST) |=> rega_out == $past(const_q));

  assert_const_keep_R9: assert property (@(posedge clk) disable iff (rst)
    !instr_is_data |=> $stable(const_q));
endmodule

bind dbus_router dbus_router_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .instr_word(instr_word), .instr_is_data(instr_is_data),
  .xfer_en(xfer_en), .xfer_dest(xfer_dest), .rega_sel(rega_sel),
  .multo_sel(multo_sel), .const_q(const_q), .rega_load(rega_load),
  .multo_load(multo_load), .rega_out(rega_out), .multo_out(multo_out)
);

// File: tb/dbus_router_bench.sv
module dbus_router_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] instr_word = '0;
  logic        instr_is_data = 1'b0;
  logic [15:0] timer_wr_reg, io_wr_reg, lifo_wr_reg, fifo_wr_reg, io_rd_reg;
  logic [15:0] pc_val, io_unit_out, alu_result, fifo_pop_val, lifo_pop_val;
  logic        xfer_en = 1'b0;
  logic        xfer_dest = 1'b0;
  logic [3:0]  rega_sel = '0;
  logic [3:0]  multo_sel = '0;
  logic [15:0] rega_out, multo_out;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 0;
  logic [15:0] m_rega = '0, m_multo = '0, m_const = '0;

  always #5 clk = ~clk;

  dbus_router u_dbus_router (
    .clk(clk), .rst(rst), .instr_word(instr_word), .instr_is_data(instr_is_data),
    .timer_wr_reg(timer_wr_reg), .io_wr_reg(io_wr_reg), .lifo_wr_reg(lifo_wr_reg),
    .fifo_wr_reg(fifo_wr_reg), .io_rd_reg(io_rd_reg), .pc_val(pc_val),
    .io_unit_out(io_unit_out), .alu_result(alu_result), .fifo_pop_val(fifo_pop_val),
    .lifo_pop_val(lifo_pop_val), .xfer_en(xfer_en), .xfer_dest(xfer_dest),
    .rega_sel(rega_sel), .multo_sel(multo_sel), .rega_out(rega_out), .multo_out(multo_out)
  );

  function automatic logic [15:0] ref_pick(input logic [3:0] code);
    case (code)
      4'b0000: return m_const;
      4'b0001: return timer_wr_reg;
      4'b0010: return io_wr_reg;
      4'b0011: return lifo_wr_reg;
      4'b0100: return fifo_wr_reg;
      4'b0101: return io_rd_reg;
      4'b0110: return pc_val;
      4'b0111: return io_unit_out;
      4'b1000: return alu_result;
      4'b1001: return fifo_pop_val;
      4'b1010: return lifo_pop_val;
      default: return 16'h0000;
    endcase
  endfunction

  task automatic set_sources(input logic [15:0] base);
    timer_wr_reg = base ^ 16'h1111; io_wr_reg    = base ^ 16'h2222;
    lifo_wr_reg  = base ^ 16'h3333; fifo_wr_reg  = base ^ 16'h4444;
    io_rd_reg    = base ^ 16'h5555; pc_val       = base ^ 16'h6666;
    io_unit_out  = base ^ 16'h7777; alu_result   = base ^ 16'h8888;
    fifo_pop_val = base ^ 16'h9999; lifo_pop_val = base ^ 16'hAAAA;
  endtask

  task automatic cmp(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // inputs already driven away from the edge; advance one clock and compare with the model
  task automatic step(input string tag);
    logic [15:0] va, vm;
    va = ref_pick(rega_sel);
    vm = ref_pick(multo_sel);
    if (rst) begin
      m_rega = '0; m_multo = '0; m_const = '0;
    end else begin
      if (xfer_en) begin
        if (xfer_dest) m_multo = vm; else m_rega = va;
      end
      if (instr_is_data) m_const = instr_word;
    end
    @(posedge clk);
    @(negedge clk);
    cmp(tag, "rega_out", rega_out, m_rega);
    cmp(tag, "multo_out", multo_out, m_multo);
  endtask

  task automatic xfer(input string tag, input logic dest, input logic [3:0] sa, input logic [3:0] sm);
    xfer_en = 1'b1; xfer_dest = dest; rega_sel = sa; multo_sel = sm;
    step(tag);
    xfer_en = 1'b0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000 && !done) begin
        done = 1;
        fails++;
        $display("FAIL R6 watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    set_sources(16'h0F0F);
    @(negedge clk);
    instr_word = 16'hBEEF; instr_is_data = 1'b1; xfer_en = 1'b1;
    step("R1"); step("R1");
    instr_is_data = 1'b0; xfer_en = 1'b0;
    rst = 1'b0;
    step("R1");
    // cleared constant register is seen through code 0000
    xfer("R1", 1'b0, 4'd0, 4'd0);
    xfer("R1", 1'b1, 4'd0, 4'd0);

    // R3: load the constant and read it on both destinations
    instr_word = 16'hC3A5; instr_is_data = 1'b1;
    step("R3");
    instr_is_data = 1'b0;
    xfer("R3", 1'b0, 4'd0, 4'd7);
    xfer("R3", 1'b1, 4'd9, 4'd0);

    // R2: every wired code to both destinations, two source patterns
    for (int p = 0; p < 2; p++) begin
      set_sources(p == 0 ? 16'h0000 : 16'h5A3C);
      for (int c = 1; c <= 10; c++) begin
        xfer("R2", 1'b0, 4'(c), 4'(10 - c));
        xfer("R2", 1'b1, 4'(c + 3), 4'(c));
      end
    end

    // R4: unwired codes zero a previously loaded output
    for (int c = 11; c <= 15; c++) begin
      xfer("R4", 1'b0, 4'd8, 4'd6);
      xfer("R4", 1'b1, 4'd8, 4'd6);
      xfer("R4", 1'b0, 4'(c), 4'd2);
      xfer("R4", 1'b1, 4'd3, 4'(c));
    end

    // R5: only the named destination moves
    xfer("R5", 1'b0, 4'd1, 4'd2);
    xfer("R5", 1'b1, 4'd4, 4'd5);
    set_sources(16'hFFFF);
    xfer("R5", 1'b0, 4'd6, 4'd6);
    xfer("R5", 1'b1, 4'd7, 4'd7);

    // R6: strobe low with busy inputs
    for (int k = 0; k < 6; k++) begin
      set_sources(16'(k * 16'h1357));
      rega_sel = 4'(k); multo_sel = 4'(k + 5); xfer_dest = k[0];
      step("R6");
    end

    // R7: equal selects give equal values
    for (int c = 0; c < 16; c++) begin
      xfer("R7", 1'b0, 4'(c), 4'(c));
      xfer("R7", 1'b1, 4'(c), 4'(c));
      cmp("R7", "rega_vs_multo", rega_out, multo_out);
    end

    // R8: load and code-0000 transfer on one edge
    instr_word = 16'h1234; instr_is_data = 1'b1;
    step("R8");
    instr_word = 16'h9876;
    xfer("R8", 1'b0, 4'd0, 4'd0);
    instr_is_data = 1'b0;
    xfer("R8", 1'b1, 4'd0, 4'd0);

    // R9: word changes without strobe, constant stays
    for (int k = 0; k < 4; k++) begin
      instr_word = 16'(16'h0101 * (k + 3));
      step("R9");
    end
    xfer("R9", 1'b0, 4'd0, 4'd0);
    xfer("R9", 1'b1, 4'd0, 4'd0);

    // mixed random traffic
    for (int k = 0; k < 400; k++) begin
      set_sources(16'($urandom));
      instr_word    = 16'($urandom);
      instr_is_data = 1'($urandom);
      xfer_en       = 1'($urandom);
      xfer_dest     = 1'($urandom);
      rega_sel      = 4'($urandom);
      multo_sel     = 4'($urandom);
      step("R5");
    end
    instr_is_data = 1'b0; xfer_en = 1'b0;

    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule